// File: doc/BRIEF.md
# Address Translation Window Matcher

This block compares one request address against a small set of programmable address windows, all serving one direction of a bridge. Each window has an enable, a size code, a base page and a target page. The block reports whether an enabled window contains the address, which window it is, and the address in the other address space. A parameter selects the direction. For the inbound variant, a claim input from the direct bus decode takes precedence over every window.

The windows are read combinationally from the register bank's outputs. A request is therefore matched against the register values present in its own cycle. Editing a window drops its old mapping at once, and a window whose enable is cleared is no longer matched. The result is registered, so it appears one clock after the request.

Top module: `xw_matcher`

## Requirements
- R1: A window takes part in matching only while its bit in `win_en_i` is 1. A request that falls only inside disabled windows misses.
- R2: A window covers `2 << size` bytes, where `size` is the window's 6-bit field in `win_size_i`. The address range is the window base up to, but not including, base plus that span.
- R3: The window base is the 32-bit `win_base_i` field shifted left by 12 bits, and the target is the `win_tar_i` field shifted left by 12 bits. Window i occupies bits [i*32+31:i*32] of each of these ports and bits [i*6+5:i*6] of `win_size_i`.
- R4: On a hit, `xlat_addr_o` equals target + (address - base), taken modulo 2^64.
- R5: When several enabled windows contain the address, the window with the lowest index wins.
- R6: A window whose span would run past 2^64 - 1 is clamped, so it covers every address from its base up to 2^64 - 1.
- R7: In the inbound variant, a request with `bus_claim_i` high misses regardless of the windows. In the outbound variant, `bus_claim_i` has no effect.
- R8: After reset, and in any cycle with no hit, `hit_o` is 0, `win_idx_o` is 0 and `xlat_addr_o` is 0.
- R9: The result of a request sampled at clock edge k is visible after edge k. It is computed from the window registers present at edge k. `valid_o` repeats `req_valid_i` with the same one-cycle delay.
- R10: `win_idx_o` gives the index of the winning window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request address is valid this cycle |
| req_addr_i | input | ADDR_W | Request address |
| bus_claim_i | input | 1 | Direct bus decode already owns the address (used by the inbound variant only) |
| win_en_i | input | NUM_WIN | Per-window enable |
| win_size_i | input | NUM_WIN*SIZE_W | Per-window size codes |
| win_base_i | input | NUM_WIN*PG_W | Per-window base page numbers |
| win_tar_i | input | NUM_WIN*PG_W | Per-window target page numbers |
| valid_o | output | 1 | Registered request valid |
| hit_o | output | 1 | Registered hit |
| win_idx_o | output | IDX_W | Registered index of the winning window |
| xlat_addr_o | output | ADDR_W | Registered translated address |

## Verification
The bench builds two instances with four windows, 64-bit addresses, 32-bit page fields and 6-bit size codes: one inbound and one outbound. Both receive identical stimulus. This lets one claim pattern show the claim blocking a hit in the inbound variant and leaving the outbound variant unaffected. The 6-bit size code reaches the value 63, so a window based high in the space overflows the 64-bit range. This exercises the clamp at the top of the space. Overlapping windows of 4 KB and 64 KB sit at the same base, which covers the priority order and both window edges.

// File: rtl/xw_pkg.sv
package xw_pkg;
  typedef enum logic {XW_OUTBOUND = 1'b0, XW_INBOUND = 1'b1} xw_dir_e;
endpackage

// File: rtl/xw_win_cmp.sv
module xw_win_cmp #(
  parameter int ADDR_W   = 64,
  parameter int PG_W     = 32,
  parameter int PG_SHIFT = 12,
  parameter int SIZE_W   = 6
) (
  input  logic              en_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [PG_W-1:0]   base_pg_i,
  input  logic [PG_W-1:0]   tar_pg_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] xlat_o
);
  localparam int EXT_W = ADDR_W + 1;

  logic [ADDR_W-1:0] base_a, tar_a;
  logic [EXT_W-1:0]  span, limit;
  logic              above, below;

  assign base_a = ADDR_W'(base_pg_i) << PG_SHIFT;
  assign tar_a  = ADDR_W'(tar_pg_i) << PG_SHIFT;

  // extra top bit lets the limit pass 2^ADDR_W: clamp comes for free
  assign span   = EXT_W'(2) << size_i;
  assign limit  = {1'b0, base_a} + span;
  assign above  = addr_i >= base_a;
  assign below  = {1'b0, addr_i} < limit;

  assign hit_o  = en_i & above & below;
  assign xlat_o = tar_a + (addr_i - base_a);
endmodule

// File: rtl/xw_prio_pick.sv
module xw_prio_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;

  always_comb begin
    if (any_o) p_pick_is_req_r5: assert (req_i[idx_o]);
  end
endmodule

// File: rtl/xw_matcher.sv
module xw_matcher
  import xw_pkg::*;
#(
  parameter int      NUM_WIN  = 4,
  parameter int      ADDR_W   = 64,
  parameter int      PG_W     = 32,
  parameter int      PG_SHIFT = 12,
  parameter int      SIZE_W   = 6,
  parameter xw_dir_e DIR      = XW_INBOUND,
  localparam int     IDX_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  input  logic [ADDR_W-1:0]         req_addr_i,
  input  logic                      bus_claim_i,
  input  logic [NUM_WIN-1:0]        win_en_i,
  input  logic [NUM_WIN*SIZE_W-1:0] win_size_i,
  input  logic [NUM_WIN*PG_W-1:0]   win_base_i,
  input  logic [NUM_WIN*PG_W-1:0]   win_tar_i,
  output logic                      valid_o,
  output logic                      hit_o,
  output logic [IDX_W-1:0]          win_idx_o,
  output logic [ADDR_W-1:0]         xlat_addr_o
);
  logic [NUM_WIN-1:0] win_hit;
  logic [ADDR_W-1:0]  win_xl [NUM_WIN];
  logic               any_hit, claim_eff, nxt_hit;
  logic [IDX_W-1:0]   pick_idx;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    xw_win_cmp #(
      .ADDR_W(ADDR_W), .PG_W(PG_W), .PG_SHIFT(PG_SHIFT), .SIZE_W(SIZE_W)
    ) u_cmp (
      .en_i     (win_en_i[g]),
      .size_i   (win_size_i[g*SIZE_W +: SIZE_W]),
      .base_pg_i(win_base_i[g*PG_W +: PG_W]),
      .tar_pg_i (win_tar_i[g*PG_W +: PG_W]),
      .addr_i   (req_addr_i),
      .hit_o    (win_hit[g]),
      .xlat_o   (win_xl[g])
    );
  end

  xw_prio_pick #(.N(NUM_WIN), .IDX_W(IDX_W)) u_pick (
    .req_i(win_hit),
    .any_o(any_hit),
    .idx_o(pick_idx)
  );

  // inbound windows sit below the direct bus decode
  if (DIR == XW_INBOUND) begin : g_inb
    assign claim_eff = bus_claim_i;
  end else begin : g_outb
    assign claim_eff = 1'b0;
  end

  assign nxt_hit = req_valid_i & ~claim_eff & any_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      hit_o       <= 1'b0;
      win_idx_o   <= '0;
      xlat_addr_o <= '0;
    end else begin
      valid_o     <= req_valid_i;
      hit_o       <= nxt_hit;
      win_idx_o   <= nxt_hit ? pick_idx : '0;
      xlat_addr_o <= nxt_hit ? win_xl[pick_idx] : '0;
    end
  end

  p_miss_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (win_idx_o == '0 && xlat_addr_o == '0));

  p_hit_has_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> valid_o);

  p_idle_next_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!valid_o && !hit_o));

  p_req_next_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> valid_o);

  p_claim_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (DIR == XW_INBOUND && bus_claim_i) |=> !hit_o);

  p_all_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_en_i == '0) |=> !hit_o);
endmodule

// File: tb/xw_matcher_tb_top.sv
module xw_matcher_tb_top;
  import xw_pkg::*;
  localparam int NW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        v = 1'b0, cl = 1'b0;
  logic [63:0] a = '0;
  logic [NW-1:0] t_en = '0;
  logic [5:0]  t_sz   [NW];
  logic [31:0] t_base [NW];
  logic [31:0] t_tar  [NW];
  logic [NW*6-1:0]  f_sz;
  logic [NW*32-1:0] f_base, f_tar;

  for (genvar g = 0; g < NW; g++) begin : g_flat
    assign f_sz[g*6 +: 6]     = t_sz[g];
    assign f_base[g*32 +: 32] = t_base[g];
    assign f_tar[g*32 +: 32]  = t_tar[g];
  end

  logic        iv, ih, ov, oh;
  logic [1:0]  ii, oi;
  logic [63:0] ix, ox;

  xw_matcher #(.NUM_WIN(NW), .DIR(XW_INBOUND)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(v), .req_addr_i(a),
    .bus_claim_i(cl), .win_en_i(t_en), .win_size_i(f_sz),
    .win_base_i(f_base), .win_tar_i(f_tar),
    .valid_o(iv), .hit_o(ih), .win_idx_o(ii), .xlat_addr_o(ix));

  xw_matcher #(.NUM_WIN(NW), .DIR(XW_OUTBOUND)) dut_out_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(v), .req_addr_i(a),
    .bus_claim_i(cl), .win_en_i(t_en), .win_size_i(f_sz),
    .win_base_i(f_base), .win_tar_i(f_tar),
    .valid_o(ov), .hit_o(oh), .win_idx_o(oi), .xlat_addr_o(ox));

  int n_run = 0, n_fail = 0;
  string tag = "R8";
  bit done = 1'b0;

  // behavioural reference, 128-bit arithmetic
  function automatic void ref_model(input bit inb, output logic h,
                                    output int id, output logic [63:0] x);
    logic [127:0] lo, hi, aa;
    h = 1'b0; id = 0; x = '0;
    if (!v || (inb && cl)) return;
    aa = {64'd0, a};
    for (int i = 0; i < NW; i++) begin
      lo = 128'(t_base[i]) << 12;
      hi = lo + (128'd2 << t_sz[i]);
      if (t_en[i] && aa >= lo && aa < hi) begin
        h = 1'b1; id = i;
        x = 64'((128'(t_tar[i]) << 12) + aa - lo);
        return;
      end
    end
  endfunction

  logic        e_iv, e_ih, e_ov, e_oh;
  int          e_ii, e_oi;
  logic [63:0] e_ix, e_ox;

  always @(posedge clk) begin
    if (!rst_n) begin
      e_iv = 0; e_ih = 0; e_ii = 0; e_ix = 0;
      e_ov = 0; e_oh = 0; e_oi = 0; e_ox = 0;
    end else begin
      e_iv = v; e_ov = v;
      ref_model(1'b1, e_ih, e_ii, e_ix);
      ref_model(1'b0, e_oh, e_oi, e_ox);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_run++;
      if (iv !== e_iv || ih !== e_ih || int'(ii) !== e_ii || ix !== e_ix) begin
        n_fail++;
        $display("FAIL %s inbound model: got v%0b h%0b i%0d x%h exp v%0b h%0b i%0d x%h",
                 tag, iv, ih, ii, ix, e_iv, e_ih, e_ii, e_ix);
      end
      n_run++;
      if (ov !== e_ov || oh !== e_oh || int'(oi) !== e_oi || ox !== e_ox) begin
        n_fail++;
        $display("FAIL %s outbound model: got v%0b h%0b i%0d x%h exp v%0b h%0b i%0d x%h",
                 tag, ov, oh, oi, ox, e_ov, e_oh, e_oi, e_ox);
      end
    end
  end

  task automatic chk(input string rq, input bit outb, input logic eh,
                     input int ei, input logic [63:0] ex);
    logic h; int id; logic [63:0] x;
    h = outb ? oh : ih; id = outb ? int'(oi) : int'(ii); x = outb ? ox : ix;
    n_run++;
    if (h !== eh || id !== ei || x !== ex) begin
      n_fail++;
      $display("FAIL %s %s: got h%0b i%0d x%h exp h%0b i%0d x%h",
               rq, outb ? "out" : "in", h, id, x, eh, ei, ex);
    end
  endtask

  // drive after a posedge, check after the next posedge
  task automatic req(input logic [63:0] ad, input logic vv, input logic cc);
    @(posedge clk); #2;
    a = ad; v = vv; cl = cc;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_sz[0] = 6'd11; t_base[0] = 32'h10;       t_tar[0] = 32'h200;
    t_sz[1] = 6'd15; t_base[1] = 32'h10;       t_tar[1] = 32'h300;
    t_sz[2] = 6'd12; t_base[2] = 32'h40;       t_tar[2] = 32'h500;
    t_sz[3] = 6'd63; t_base[3] = 32'h8000_0000; t_tar[3] = 32'h1;
    t_en = 4'b1011;
    repeat (3) @(posedge clk);
    @(negedge clk);
    tag = "R8";
    chk("R8 reset", 1'b0, 1'b0, 0, 64'd0);
    n_run++;
    if (iv !== 1'b0) begin n_fail++; $display("FAIL R8 reset valid: got %b exp 0", iv); end
    #2 rst_n = 1'b1;

    tag = "R4";
    req(64'h10010, 1, 0);
    chk("R4 R3 R10 win0", 1'b0, 1'b1, 0, 64'h200010);
    tag = "R2";
    req(64'h10FFF, 1, 0);
    chk("R2 win0 top byte", 1'b0, 1'b1, 0, 64'h200FFF);
    tag = "R5";
    req(64'h11000, 1, 0);
    chk("R5 R2 win1 past win0", 1'b0, 1'b1, 1, 64'h301000);
    req(64'h1FFFF, 1, 0);
    chk("R2 win1 top byte", 1'b0, 1'b1, 1, 64'h30FFFF);
    tag = "R8";
    req(64'h20000, 1, 0);
    chk("R8 R2 just past win1", 1'b0, 1'b0, 0, 64'd0);
    req(64'hF000, 1, 0);
    chk("R2 below base", 1'b0, 1'b0, 0, 64'd0);

    tag = "R1";
    req(64'h40020, 1, 0);
    chk("R1 disabled win2", 1'b0, 1'b0, 0, 64'd0);
    @(posedge clk); #2; t_en[2] = 1'b1;
    @(posedge clk); @(negedge clk);
    tag = "R9";
    chk("R9 R1 enabled win2", 1'b0, 1'b1, 2, 64'h500020);
    @(posedge clk); #2; t_en[2] = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R1 R9 win2 cleared", 1'b0, 1'b0, 0, 64'd0);
    @(posedge clk); #2; t_tar[0] = 32'h700;
    @(posedge clk); @(negedge clk);
    chk("R9 retarget win0", 1'b0, 1'b0, 0, 64'd0);
    req(64'h10010, 1, 0);
    chk("R9 R4 new target", 1'b0, 1'b1, 0, 64'h700010);
    t_tar[0] = 32'h200;

    tag = "R6";
    req(64'hFFFF_FFFF_FFFF_FFFF, 1, 0);
    chk("R6 clamp top", 1'b0, 1'b1, 3, 64'hFFFF_F800_0000_0FFF);
    req(64'h0000_0800_0000_0000, 1, 0);
    chk("R6 clamp base", 1'b0, 1'b1, 3, 64'h1000);
    req(64'h0000_07FF_FFFF_FFFF, 1, 0);
    chk("R6 below clamp base", 1'b0, 1'b0, 0, 64'd0);

    tag = "R7";
    req(64'h10010, 1, 1);
    chk("R7 inbound claimed", 1'b0, 1'b0, 0, 64'd0);
    chk("R7 outbound ignores claim", 1'b1, 1'b1, 0, 64'h200010);

    tag = "R8";
    req(64'h10010, 0, 0);
    chk("R8 idle", 1'b0, 1'b0, 0, 64'd0);
    n_run++;
    if (iv !== 1'b0) begin n_fail++; $display("FAIL R9 idle valid: got %b exp 0", iv); end

    tag = "R9";
    req(64'h11004, 1, 0);
    chk("R9 one cycle", 1'b0, 1'b1, 1, 64'h301004);
    n_run++;
    if (iv !== 1'b1) begin n_fail++; $display("FAIL R9 valid: got %b exp 1", iv); end
    @(posedge clk); #2; v = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R9 drops after request", 1'b0, 1'b0, 0, 64'd0);

    repeat (2) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule